// File: doc/BRIEF.md
# 32-bit Conditional Branch Evaluator

This combinational block resolves conditional branches whose operands are compared at 32-bit width. It takes an 8-bit opcode, the 64-bit destination and source register values, a 32-bit immediate, a signed 16-bit displacement and the current program counter. From these it drives a taken flag, the next program counter and an invalid-opcode flag.

Only the low 32 bits of each operand take part in the comparison. Depending on the condition, they are compared as unsigned values, as two's-complement values, or through a bitwise AND test. The upper 32 bits of both registers have no effect. The block sits between register read and the program-counter register of an execution stage. The program counter counts instruction slots.

Top module: `brc32_eval`

## Requirements
- R1: Opcode fields are laid out as follows. Bits [2:0] equal 3'b110 for this branch class. Bit 3 selects the second operand: 0 selects the immediate, 1 selects the low word of the source register. Bits [7:4] hold the condition: 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 bit test, 5 not equal, 6 signed greater, 7 signed greater-or-equal, 0xA unsigned less, 0xB unsigned less-or-equal, 0xC signed less, 0xD signed less-or-equal.
- R2: Only bits [31:0] of the destination and of the source register take part in the comparison. Changing bits [63:32] of either register never changes `taken_o`.
- R3: Conditions 2, 3, 0xA and 0xB compare the two 32-bit operands as unsigned numbers.
- R4: Conditions 6, 7, 0xC and 0xD compare the two 32-bit operands as two's-complement numbers. Condition 7 is a true greater-or-equal, so equal operands take the branch.
- R5: Condition 4 takes the branch exactly when the AND of the two 32-bit operands is non-zero.
- R6: When the branch is taken, `next_pc_o` equals `pc_i` plus the sign-extended `offset_i`, modulo 2^64.
- R7: When the branch is not taken, `next_pc_o` equals `pc_i + 1`, modulo 2^64.
- R8: An opcode of this class whose condition field is 0, 8, 9, 0xE or 0xF raises `bad_op_o` and forces `taken_o` low.
- R9: An opcode whose bits [2:0] differ from 3'b110 leaves `bad_op_o` and `taken_o` low.
- R10: Condition 1 takes the branch exactly when the operands are equal. Condition 5 takes it exactly when they differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Instruction opcode |
| dst_i | input | 64 | Destination register value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate operand |
| offset_i | input | 16 | Signed branch displacement in slots |
| pc_i | input | 64 | Current program counter |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 64 | Next program counter |
| bad_op_o | output | 1 | Unlisted opcode of this class |

## Verification
The bench builds the block with its defaults: 64-bit registers and program counter, 32-bit compare width, 32-bit immediate and 16-bit displacement. Because the compare width is half the register width, the bench can place arbitrary patterns in the upper register bits while sweeping every condition over the values where the signed and unsigned orders disagree (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF). The 64-bit program counter also lets the bench check wraparound at the top of the address space, together with the most negative and most positive displacements.

// File: rtl/brc32_pkg.sv
package brc32_pkg;
  localparam logic [2:0] CLASS_BR32 = 3'b110;

  typedef enum logic [3:0] {
    COND_NONE = 4'h0,
    COND_EQ   = 4'h1,
    COND_UGT  = 4'h2,
    COND_UGE  = 4'h3,
    COND_TST  = 4'h4,
    COND_NE   = 4'h5,
    COND_SGT  = 4'h6,
    COND_SGE  = 4'h7,
    COND_ULT  = 4'hA,
    COND_ULE  = 4'hB,
    COND_SLT  = 4'hC,
    COND_SLE  = 4'hD
  } cond_e;
endpackage

// File: rtl/brc32_decode.sv
module brc32_decode
  import brc32_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode_i,
  output cond_e            cond_o,
  output logic             use_reg_o,
  output logic             in_class_o,
  output logic             known_o
);
  always_comb begin
    in_class_o = (opcode_i[2:0] == CLASS_BR32);
    use_reg_o  = opcode_i[3];
    known_o    = 1'b1;
    unique case (opcode_i[7:4])
      4'h1: cond_o = COND_EQ;
      4'h2: cond_o = COND_UGT;
      4'h3: cond_o = COND_UGE;
      4'h4: cond_o = COND_TST;
      4'h5: cond_o = COND_NE;
      4'h6: cond_o = COND_SGT;
      4'h7: cond_o = COND_SGE;
      4'hA: cond_o = COND_ULT;
      4'hB: cond_o = COND_ULE;
      4'hC: cond_o = COND_SLT;
      4'hD: cond_o = COND_SLE;
      default: begin
        cond_o  = COND_NONE;
        known_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/brc32_compare.sv
module brc32_compare
  import brc32_pkg::*;
#(
  parameter int CMP_W = 32
) (
  input  logic [CMP_W-1:0] a_i,
  input  logic [CMP_W-1:0] b_i,
  input  cond_e            cond_i,
  output logic             hit_o
);
  logic eq, ult, slt, any_set;

  // One subtractor gives both orders; signed differs only when the sign bits differ
  logic [CMP_W:0] diff;
  assign diff    = {1'b0, a_i} - {1'b0, b_i};
  assign eq      = (a_i == b_i);
  assign ult     = diff[CMP_W];
  assign slt     = (a_i[CMP_W-1] ^ b_i[CMP_W-1]) ? a_i[CMP_W-1] : ult;
  assign any_set = |(a_i & b_i);

  always_comb begin
    unique case (cond_i)
      COND_EQ:  hit_o = eq;
      COND_NE:  hit_o = !eq;
      COND_UGT: hit_o = !ult && !eq;
      COND_UGE: hit_o = !ult;
      COND_ULT: hit_o = ult;
      COND_ULE: hit_o = ult || eq;
      COND_SGT: hit_o = !slt && !eq;
      COND_SGE: hit_o = !slt;
      COND_SLT: hit_o = slt;
      COND_SLE: hit_o = slt || eq;
      COND_TST: hit_o = any_set;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc32_next_pc.sv
module brc32_next_pc #(
  parameter int PC_W  = 64,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic             take_i,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] step;

  generate
    if (EXT_W > 0) begin : g_ext
      assign step = take_i ? {{EXT_W{offset_i[OFF_W-1]}}, offset_i}
                           : {{(PC_W-1){1'b0}}, 1'b1};
    end else begin : g_trunc
      assign step = take_i ? offset_i[PC_W-1:0] : {{(PC_W-1){1'b0}}, 1'b1};
    end
  endgenerate

  assign next_pc_o = pc_i + step;
endmodule

// File: rtl/brc32_eval.sv
module brc32_eval
  import brc32_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int CMP_W = 32,
  parameter int IMM_W = 32,
  parameter int OFF_W = 16,
  parameter int PC_W  = 64,
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             bad_op_o
);
  cond_e            cond;
  logic             use_reg, in_class, known, hit;
  logic [CMP_W-1:0] opa, opb;

  brc32_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode_i  (opcode_i),
    .cond_o    (cond),
    .use_reg_o (use_reg),
    .in_class_o(in_class),
    .known_o   (known)
  );

  assign opa = dst_i[CMP_W-1:0];
  assign opb = use_reg ? src_i[CMP_W-1:0] : imm_i[CMP_W-1:0];

  brc32_compare #(.CMP_W(CMP_W)) u_cmp (
    .a_i   (opa),
    .b_i   (opb),
    .cond_i(cond),
    .hit_o (hit)
  );

  assign taken_o  = in_class && known && hit;
  assign bad_op_o = in_class && !known;

  brc32_next_pc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_npc (
    .pc_i     (pc_i),
    .offset_i (offset_i),
    .take_i   (taken_o),
    .next_pc_o(next_pc_o)
  );
endmodule

// File: rtl/brc32_eval_chk.sv
module brc32_eval_chk #(
  parameter int OPC_W = 8,
  parameter int REG_W = 64,
  parameter int IMM_W = 32,
  parameter int OFF_W = 16,
  parameter int PC_W  = 64
) (
  input logic [OPC_W-1:0] opcode_i,
  input logic [REG_W-1:0] dst_i,
  input logic [REG_W-1:0] src_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [OFF_W-1:0] offset_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             taken_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             bad_op_o
);
  logic [PC_W-1:0] sext_off;
  assign sext_off = PC_W'($signed(offset_i));

  always_comb begin
    AST_BAD_NOT_TAKEN: assert (!(bad_op_o && taken_o)); // R8
    AST_FOREIGN_QUIET: assert (opcode_i[2:0] == 3'b110 || (!bad_op_o && !taken_o)); // R9
    AST_TAKEN_TARGET: assert (!taken_o || next_pc_o == pc_i + sext_off); // R6
    AST_FALL_THROUGH: assert (taken_o || next_pc_o == pc_i + PC_W'(1)); // R7
    AST_TEST_ZERO: assert (!(opcode_i[7:4] == 4'h4 && opcode_i[2:0] == 3'b110
                             && ((dst_i[31:0] & (opcode_i[3] ? src_i[31:0] : imm_i[31:0])) == 32'd0))
                           || !taken_o); // R5
  end
endmodule

bind brc32_eval brc32_eval_chk #(
  .OPC_W(OPC_W), .REG_W(REG_W), .IMM_W(IMM_W), .OFF_W(OFF_W), .PC_W(PC_W)
) u_chk (
  .opcode_i (opcode_i),
  .dst_i    (dst_i),
  .src_i    (src_i),
  .imm_i    (imm_i),
  .offset_i (offset_i),
  .pc_i     (pc_i),
  .taken_o  (taken_o),
  .next_pc_o(next_pc_o),
  .bad_op_o (bad_op_o)
);

// File: tb/brc32_eval_test.sv
module brc32_eval_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  opcode;
  logic [63:0] dst, src, pc;
  logic [31:0] imm;
  logic [15:0] offset;
  logic        taken, bad_op;
  logic [63:0] next_pc;
  int          n_checks = 0;
  int          n_errors = 0;

  always #5 clk = ~clk;

  brc32_eval uut (
    .opcode_i (opcode),
    .dst_i    (dst),
    .src_i    (src),
    .imm_i    (imm),
    .offset_i (offset),
    .pc_i     (pc),
    .taken_o  (taken),
    .next_pc_o(next_pc),
    .bad_op_o (bad_op)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s op=%h: got %h expected %h", req, what, opcode, got, exp);
    end
  endtask

  // Expected decision taken from the requirement text
  function automatic logic ref_take(input logic [7:0] op, input logic [63:0] d,
                                    input logic [63:0] s, input logic [31:0] im);
    logic [31:0] a, b;
    a = d[31:0];
    b = op[3] ? s[31:0] : im;
    if (op[2:0] != 3'b110) return 1'b0;
    case (op[7:4])
      4'h1: return a == b;
      4'h2: return a > b;
      4'h3: return a >= b;
      4'h4: return (a & b) != 0;
      4'h5: return a != b;
      4'h6: return $signed(a) > $signed(b);
      4'h7: return $signed(a) >= $signed(b);
      4'hA: return a < b;
      4'hB: return a <= b;
      4'hC: return $signed(a) < $signed(b);
      4'hD: return $signed(a) <= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'h1, 4'h5: return "R10";
      4'h2, 4'h3, 4'hA, 4'hB: return "R3";
      4'h4: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] im, input logic [15:0] off, input logic [63:0] p);
    @(posedge clk);
    opcode = op; dst = d; src = s; imm = im; offset = off; pc = p;
    @(negedge clk);
  endtask

  task automatic t_reset;
    apply(8'h00, '0, '0, '0, '0, '0);
    chk("R9", "taken", {63'd0, taken}, 64'd0);
    chk("R9", "bad", {63'd0, bad_op}, 64'd0);
    chk("R7", "next_pc", next_pc, 64'd1);
  endtask

  task automatic t_sweep;
    logic [31:0] v [5];
    logic [3:0]  conds [11];
    v = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    conds = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB, 4'hC, 4'hD};
    for (int c = 0; c < 11; c++)
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++) begin
            logic [7:0]  op;
            logic [63:0] d, s;
            logic        e;
            op = {conds[c], r[0], 3'b110};
            d  = {32'hDEAD_BEEF, v[i]};
            s  = {32'h1234_5678, v[j]};
            e  = ref_take(op, d, s, v[j]);
            apply(op, d, s, r[0] ? 32'hA5A5_5A5A : v[j], 16'h0010, 64'h100);
            if (r[0]) e = ref_take(op, d, s, 32'hA5A5_5A5A);
            chk(req_of(conds[c]), "taken", {63'd0, taken}, {63'd0, e});
            chk(e ? "R6" : "R7", "next_pc", next_pc, e ? 64'h110 : 64'h101);
          end
  endtask

  task automatic t_high_bits;
    apply(8'h16, 64'hFFFF_FFFF_0000_0000, '0, 32'h0, 16'h4, 64'h0);
    chk("R2", "eq hi ignored", {63'd0, taken}, 64'd1);
    apply(8'h4E, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, '0, 16'h4, 64'h0);
    chk("R2", "test hi ignored", {63'd0, taken}, 64'd0);
    apply(8'hAE, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0002, '0, 16'h4, 64'h0);
    chk("R2", "ult hi ignored", {63'd0, taken}, 64'd1);
    apply(8'h7E, 64'h8000_0000_0000_0005, 64'h0000_0000_0000_0005, '0, 16'h4, 64'h0);
    chk("R4", "sge equal", {63'd0, taken}, 64'd1);
  endtask

  task automatic t_pc;
    apply(8'h16, '0, '0, '0, 16'hFFFF, 64'h20);
    chk("R6", "offset -1", next_pc, 64'h1F);
    apply(8'h16, '0, '0, '0, 16'h8000, 64'h10000);
    chk("R6", "offset min", next_pc, 64'h8000);
    apply(8'h16, '0, '0, '0, 16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6", "wrap", next_pc, 64'h7FFE);
    apply(8'h56, '0, '0, '0, 16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7", "fall wrap", next_pc, 64'h0);
  endtask

  task automatic t_bad;
    logic [3:0] bad [5];
    bad = '{4'h0, 4'h8, 4'h9, 4'hE, 4'hF};
    for (int i = 0; i < 5; i++)
      for (int r = 0; r < 2; r++) begin
        apply({bad[i], r[0], 3'b110}, 64'h5, 64'h5, 32'h5, 16'h40, 64'h8);
        chk("R8", "bad", {63'd0, bad_op}, 64'd1);
        chk("R8", "taken", {63'd0, taken}, 64'd0);
        chk("R8", "next_pc", next_pc, 64'h9);
      end
  endtask

  task automatic t_foreign;
    logic [7:0] ops [4];
    ops = '{8'h15, 8'h1D, 8'h05, 8'h17};
    for (int i = 0; i < 4; i++) begin
      apply(ops[i], 64'h3, 64'h3, 32'h3, 16'h40, 64'h8);
      chk("R9", "bad", {63'd0, bad_op}, 64'd0);
      chk("R9", "taken", {63'd0, taken}, 64'd0);
      chk("R1", "next_pc", next_pc, 64'h9);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    opcode = '0; dst = '0; src = '0; imm = '0; offset = '0; pc = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_sweep();
    t_high_bits();
    t_pc();
    t_bad();
    t_foreign();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule